// File: doc/BRIEF.md
# Unaligned Access Bus-Cycle Splitter

This block sits between a processor's load/store path and a fixed-width external data bus. It accepts a request for 1, 2 or 4 bytes at any byte address. It turns the request into the shortest sequence of aligned bus transactions that covers exactly those bytes. Each transaction presents a bus-aligned word address. Per-lane byte enables select the wanted bytes, so a lane holding a byte outside the request is never strobed. This protects memory-mapped devices whose registers change state when they are read.

A parameter sets the data bus to 2 byte lanes (16-bit) or 4 byte lanes (32-bit). The number of transactions therefore depends on both the start offset and the bus width. Every transaction has a one-clock address phase followed by a data phase. The data phase ends at the first clock edge where the bus reports ready. On a write, each source byte is rotated onto the lane that matches its address. On a read, the bytes returned on the enabled lanes are packed in order into a right-justified result. When the last transaction ends, a one-clock done pulse is given, together with the number of transactions the request used.

Top module: `unaligned_bus_splitter`

## Requirements
- R1: `req_ready` is high only while no request is in progress. A request is taken only when `req_valid` and `req_ready` are both high. A request raised while busy is ignored: it adds no transaction and writes nothing.
- R2: While `bus_active` is high, the low log2(BUS_BYTES) bits of `bus_addr` are zero.
- R3: `req_size` holds the byte count (1, 2 or 4). Each transaction carries the requested bytes from the current address up to the next multiple of BUS_BYTES, or up to the last requested byte if that comes first. `rsp_count` reports the number of transactions.
- R4: `bus_be` bit i refers to the byte at `bus_addr + i`. The bit is set only when that byte is part of the request. `bus_be` is zero when no transaction is active. A write leaves the bytes next to the request unchanged.
- R5: With BUS_BYTES=4, a 4-byte access takes 1 transaction at offset 0 and 2 transactions at offset 1, 2 or 3. A 2-byte access takes 1 transaction unless the address modulo 4 is 3, in which case it takes 2.
- R6: With BUS_BYTES=2, a 4-byte access at address 3 takes 3 transactions (byte 3, bytes 4-5, byte 6). At address 6 it takes 2 transactions.
- R7: Each transaction has an address phase of exactly one clock (`bus_addr_strobe` high), then a data phase that holds address and enables stable until `bus_ready` is sampled high. A transaction therefore takes 2 clocks plus one per wait clock. `rsp_done` rises in the clock after the final transaction completes.
- R8: On a write, request byte k (`req_wdata` bits 8k+7..8k) is driven on lane (address+k) mod BUS_BYTES, bits 8·lane+7..8·lane of `bus_wdata`. Lanes that are not enabled are driven to zero.
- R9: On a read, byte k of `rsp_rdata` is the byte at address+k. Bytes at k ≥ size are zero. The result is valid with `rsp_done` and holds until the next request is accepted.
- R10: `rsp_done` is high for exactly one clock per request, and only while idle. `rsp_count` holds its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Byte address of the first requested byte |
| req_size | input | $clog2(REQ_BYTES+1) | Byte count: 1, 2 or 4 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8*REQ_BYTES | Write data, byte 0 in bits 7..0 |
| req_ready | output | 1 | Idle; a request is accepted this cycle |
| bus_addr | output | ADDR_W | Bus-aligned transaction address |
| bus_be | output | BUS_BYTES | Byte-lane enables |
| bus_wdata | output | 8*BUS_BYTES | Lane-steered write data |
| bus_write | output | 1 | Active transaction is a write |
| bus_addr_strobe | output | 1 | Address phase of a transaction |
| bus_active | output | 1 | A transaction is in its address or data phase |
| bus_ready | input | 1 | Data phase ends at this clock edge |
| bus_rdata | input | 8*BUS_BYTES | Read data, all lanes |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8*REQ_BYTES | Right-justified read result |
| rsp_count | output | $clog2(REQ_BYTES+1) | Transactions used by the last request |

## Verification
The assertions assume that `req_size` is only ever 1, 2 or 4. Under that assumption the byte pointer always reaches the end of the request, and the enables can never be empty during a transaction. They also assume that `bus_ready` only matters during a data phase. The bench stimulus stays inside these limits. Every request uses a legal size, and the bus model raises ready only in data phases, after a programmed number of wait clocks. Addresses are kept inside the model's 64-byte window, so that the bytes next to each request can be read back.

// File: rtl/splitter_pkg.sv
// Shared types for the unaligned access splitter.
// Assumes: nothing beyond a single clock domain.
package splitter_pkg;

    // Sequencer phases: idle, address phase, data phase
    typedef enum logic [1:0] {
        SPLIT_IDLE = 2'd0,
        SPLIT_ADDR = 2'd1,
        SPLIT_DATA = 2'd2
    } split_state_e;

endpackage

// File: rtl/lane_planner.sv
// Computes how many requested bytes fit into the current bus word and
// which lanes they occupy.
// Assumes: remain is at least 1 whenever the result is used.
module lane_planner #(
    parameter int BUS_BYTES = 4,
    parameter int REQ_BYTES = 4,
    localparam int LANE_W = $clog2(BUS_BYTES),
    localparam int CNT_W  = $clog2(REQ_BYTES + 1)
) (
    input  logic [LANE_W-1:0]    off,
    input  logic [CNT_W-1:0]     remain,
    output logic [CNT_W-1:0]     take,
    output logic [BUS_BYTES-1:0] be
);

    int room;
    int span;

    // Bytes taken: the smaller of room-to-boundary and bytes still owed
    always_comb begin
        room = BUS_BYTES - int'(off);
        span = (int'(remain) < room) ? int'(remain) : room;
        take = CNT_W'(span);
    end

    // One enable per lane, set inside the window [off, off+span)
    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_be
        assign be[i] = (i >= int'(off)) && (i < int'(off) + span);
    end

endmodule

// File: rtl/write_steer.sv
// Rotates request bytes onto the bus lanes that match their addresses.
// Assumes: base counts bytes already sent; disabled lanes are driven zero.
module write_steer #(
    parameter int BUS_BYTES = 4,
    parameter int REQ_BYTES = 4,
    localparam int LANE_W = $clog2(BUS_BYTES),
    localparam int CNT_W  = $clog2(REQ_BYTES + 1)
) (
    input  logic [8*REQ_BYTES-1:0] src,
    input  logic [LANE_W-1:0]      off,
    input  logic [CNT_W-1:0]       base,
    input  logic [BUS_BYTES-1:0]   be,
    output logic [8*BUS_BYTES-1:0] lanes
);

    for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
        logic [7:0] lane_byte;
        int         idx;

        // Select source byte (base + lane - off) for an enabled lane
        always_comb begin
            lane_byte = '0;
            idx = int'(base) + i - int'(off);
            for (int k = 0; k < REQ_BYTES; k++) begin
                if (be[i] && (idx == k)) begin
                    lane_byte = src[8*k +: 8];
                end
            end
        end

        assign lanes[8*i +: 8] = lane_byte;
    end

endmodule

// File: rtl/read_gather.sv
// Packs bytes returned on enabled lanes into a right-justified result.
// Assumes: clear comes with request acceptance; capture is one clock per
// completed read transaction.
module read_gather #(
    parameter int BUS_BYTES = 4,
    parameter int REQ_BYTES = 4,
    localparam int LANE_W = $clog2(BUS_BYTES),
    localparam int CNT_W  = $clog2(REQ_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   capture,
    input  logic [BUS_BYTES-1:0]   be,
    input  logic [LANE_W-1:0]      off,
    input  logic [CNT_W-1:0]       base,
    input  logic [8*BUS_BYTES-1:0] lanes,
    output logic [8*REQ_BYTES-1:0] result
);

    // Clear on a new request, then place each enabled lane at its byte slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
        end else if (clear) begin
            result <= '0;
        end else if (capture) begin
            for (int k = 0; k < REQ_BYTES; k++) begin
                for (int i = 0; i < BUS_BYTES; i++) begin
                    if (be[i] && (int'(base) + i - int'(off) == k)) begin
                        result[8*k +: 8] <= lanes[8*i +: 8];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/unaligned_bus_splitter.sv
// Splits a 1/2/4-byte request at any byte address into aligned bus
// transactions with exact byte enables, steering write data and gathering
// read data.
// Assumes: req_size is 1, 2 or 4; bus_ready is only meaningful in a data phase.
module unaligned_bus_splitter #(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4,
    parameter int REQ_BYTES = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             req_valid,
    input  logic [ADDR_W-1:0]                req_addr,
    input  logic [$clog2(REQ_BYTES+1)-1:0]   req_size,
    input  logic                             req_write,
    input  logic [8*REQ_BYTES-1:0]           req_wdata,
    output logic                             req_ready,
    output logic [ADDR_W-1:0]                bus_addr,
    output logic [BUS_BYTES-1:0]             bus_be,
    output logic [8*BUS_BYTES-1:0]           bus_wdata,
    output logic                             bus_write,
    output logic                             bus_addr_strobe,
    output logic                             bus_active,
    input  logic                             bus_ready,
    input  logic [8*BUS_BYTES-1:0]           bus_rdata,
    output logic                             rsp_done,
    output logic [8*REQ_BYTES-1:0]           rsp_rdata,
    output logic [$clog2(REQ_BYTES+1)-1:0]   rsp_count
);
    import splitter_pkg::*;

    localparam int LANE_W = $clog2(BUS_BYTES);
    localparam int CNT_W  = $clog2(REQ_BYTES + 1);
    localparam int BUS_W  = 8 * BUS_BYTES;
    localparam int REQ_W  = 8 * REQ_BYTES;

    split_state_e         state_q;
    logic [ADDR_W-1:0]    ptr_q;
    logic [CNT_W-1:0]     left_q;
    logic [CNT_W-1:0]     sent_q;
    logic [CNT_W-1:0]     txn_q;
    logic [REQ_W-1:0]     wbuf_q;
    logic                 wr_q;
    logic                 done_q;

    logic [LANE_W-1:0]    off;
    logic [CNT_W-1:0]     take;
    logic [BUS_BYTES-1:0] lane_en;
    logic [BUS_W-1:0]     steered;
    logic                 accept;
    logic                 xfer_end;
    logic                 final_xfer;

    // Handshake and phase decode
    assign req_ready       = (state_q == SPLIT_IDLE);
    assign accept          = req_valid && req_ready;
    assign bus_addr_strobe = (state_q == SPLIT_ADDR);
    assign bus_active      = (state_q != SPLIT_IDLE);
    assign xfer_end        = (state_q == SPLIT_DATA) && bus_ready;
    assign final_xfer      = (left_q == take);
    assign off             = ptr_q[LANE_W-1:0];

    lane_planner #(
        .BUS_BYTES(BUS_BYTES),
        .REQ_BYTES(REQ_BYTES)
    ) u_plan (
        .off   (off),
        .remain(left_q),
        .take  (take),
        .be    (lane_en)
    );

    write_steer #(
        .BUS_BYTES(BUS_BYTES),
        .REQ_BYTES(REQ_BYTES)
    ) u_steer (
        .src  (wbuf_q),
        .off  (off),
        .base (sent_q),
        .be   (lane_en),
        .lanes(steered)
    );

    read_gather #(
        .BUS_BYTES(BUS_BYTES),
        .REQ_BYTES(REQ_BYTES)
    ) u_gather (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .capture(xfer_end && !wr_q),
        .be     (lane_en),
        .off    (off),
        .base   (sent_q),
        .lanes  (bus_rdata),
        .result (rsp_rdata)
    );

    // Bus outputs: aligned address, enables and data only while active
    assign bus_addr  = {ptr_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    assign bus_be    = bus_active ? lane_en : '0;
    assign bus_write = bus_active && wr_q;
    assign bus_wdata = bus_write ? steered : '0;
    assign rsp_done  = done_q;
    assign rsp_count = txn_q;

    // Sequencer: latch request, step address/data phases, advance byte pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SPLIT_IDLE;
            ptr_q   <= '0;
            left_q  <= '0;
            sent_q  <= '0;
            txn_q   <= '0;
            wbuf_q  <= '0;
            wr_q    <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= xfer_end && final_xfer;
            case (state_q)
                SPLIT_IDLE: begin
                    if (accept) begin
                        ptr_q   <= req_addr;
                        left_q  <= req_size;
                        sent_q  <= '0;
                        txn_q   <= '0;
                        wbuf_q  <= req_wdata;
                        wr_q    <= req_write;
                        state_q <= SPLIT_ADDR;
                    end
                end
                SPLIT_ADDR: begin
                    state_q <= SPLIT_DATA;
                end
                SPLIT_DATA: begin
                    if (bus_ready) begin
                        ptr_q   <= ptr_q + ADDR_W'(take);
                        left_q  <= left_q - take;
                        sent_q  <= sent_q + take;
                        txn_q   <= txn_q + 1'b1;
                        state_q <= final_xfer ? SPLIT_IDLE : SPLIT_ADDR;
                    end
                end
                default: state_q <= SPLIT_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/splitter_checker.sv
// Protocol properties of the splitter, bound into every instance.
// Assumes: the same legal-size and ready-in-data-phase rules as the design.
module splitter_checker #(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 4,
    parameter int REQ_BYTES = 4
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           req_valid,
    input logic                           req_ready,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic [BUS_BYTES-1:0]           bus_be,
    input logic                           bus_addr_strobe,
    input logic                           bus_active,
    input logic                           rsp_done,
    input logic [$clog2(REQ_BYTES+1)-1:0] rsp_count
);
    localparam int LANE_W = $clog2(BUS_BYTES);

    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_aligned_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |-> (bus_addr[LANE_W-1:0] == '0));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (rsp_count != '0) && (int'(rsp_count) <= REQ_BYTES));

    assert_quiet_lanes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_active |-> (bus_be == '0));

    assert_some_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active |-> (bus_be != '0));

    assert_addr_phase_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_addr_strobe |=> bus_active && !bus_addr_strobe);

    assert_data_phase_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_active && !bus_addr_strobe |-> $stable(bus_addr) && $stable(bus_be));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready && !bus_active);

endmodule

bind unaligned_bus_splitter splitter_checker #(
    .ADDR_W   (ADDR_W),
    .BUS_BYTES(BUS_BYTES),
    .REQ_BYTES(REQ_BYTES)
) u_check (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .bus_addr       (bus_addr),
    .bus_be         (bus_be),
    .bus_addr_strobe(bus_addr_strobe),
    .bus_active     (bus_active),
    .rsp_done       (rsp_done),
    .rsp_count      (rsp_count)
);

// File: tb/unaligned_bus_splitter_test.sv
`timescale 1ns/1ps

// Bench-side bus model: 64-byte memory, programmable wait clocks, and a
// log of every completed transaction.
module bus_responder #(
    parameter int BUS_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  int                     wait_cfg,
    input  logic [31:0]            bus_addr,
    input  logic [BUS_BYTES-1:0]   bus_be,
    input  logic [8*BUS_BYTES-1:0] bus_wdata,
    input  logic                   bus_write,
    input  logic                   bus_addr_strobe,
    input  logic                   bus_active,
    output logic                   bus_ready,
    output logic [8*BUS_BYTES-1:0] bus_rdata
);
    logic [7:0]  mem [0:63];
    logic [31:0] log_addr [0:127];
    logic [3:0]  log_be [0:127];
    logic [31:0] log_wd [0:127];
    int          nlog;
    int          wcnt;
    logic        data_phase;

    assign data_phase = bus_active && !bus_addr_strobe;
    assign bus_ready  = data_phase && (wcnt >= wait_cfg);

    // Read lanes: memory bytes on enabled lanes, filler on the rest
    always_comb begin
        for (int i = 0; i < BUS_BYTES; i++) begin
            bus_rdata[8*i +: 8] = bus_be[i] ? mem[6'(bus_addr[5:0] + 6'(i))] : 8'hEE;
        end
    end

    // Wait counting, memory writes and the transaction log
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt <= 0;
            nlog <= 0;
            for (int i = 0; i < 64; i++) mem[i] <= 8'(i * 7 + 33);
        end else begin
            wcnt <= data_phase ? wcnt + 1 : 0;
            if (bus_ready) begin
                if (bus_write) begin
                    for (int i = 0; i < BUS_BYTES; i++) begin
                        if (bus_be[i]) mem[6'(bus_addr[5:0] + 6'(i))] <= bus_wdata[8*i +: 8];
                    end
                end
                log_addr[nlog[6:0]] <= bus_addr;
                log_be[nlog[6:0]]   <= 4'(bus_be);
                log_wd[nlog[6:0]]   <= 32'(bus_wdata);
                nlog <= nlog + 1;
                wcnt <= 0;
            end
        end
    end
endmodule

module unaligned_bus_splitter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_w = 1'b0, vld_n = 1'b0;
    logic [31:0] req_addr = '0;
    logic [2:0]  req_size = 3'd1;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    int          wait_cfg = 0;

    logic        rdy_w, rdy_n, done_w, done_n;
    logic [31:0] rd_w, rd_n;
    logic [2:0]  cnt_w, cnt_n;
    logic [31:0] ba_w, ba_n;
    logic [3:0]  be_w;
    logic [1:0]  be_n;
    logic [31:0] wd_w, rdat_w;
    logic [15:0] wd_n, rdat_n;
    logic        bw_w, bw_n, as_w, as_n, act_w, act_n, br_w, br_n;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    unaligned_bus_splitter #(.ADDR_W(32), .BUS_BYTES(4), .REQ_BYTES(4)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(vld_w), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(rdy_w), .bus_addr(ba_w), .bus_be(be_w), .bus_wdata(wd_w),
        .bus_write(bw_w), .bus_addr_strobe(as_w), .bus_active(act_w),
        .bus_ready(br_w), .bus_rdata(rdat_w), .rsp_done(done_w),
        .rsp_rdata(rd_w), .rsp_count(cnt_w));

    unaligned_bus_splitter #(.ADDR_W(32), .BUS_BYTES(2), .REQ_BYTES(4)) uut_narrow (
        .clk(clk), .rst_n(rst_n), .req_valid(vld_n), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(rdy_n), .bus_addr(ba_n), .bus_be(be_n), .bus_wdata(wd_n),
        .bus_write(bw_n), .bus_addr_strobe(as_n), .bus_active(act_n),
        .bus_ready(br_n), .bus_rdata(rdat_n), .rsp_done(done_n),
        .rsp_rdata(rd_n), .rsp_count(cnt_n));

    bus_responder #(.BUS_BYTES(4)) rsp_w (
        .clk(clk), .rst_n(rst_n), .wait_cfg(wait_cfg), .bus_addr(ba_w),
        .bus_be(be_w), .bus_wdata(wd_w), .bus_write(bw_w),
        .bus_addr_strobe(as_w), .bus_active(act_w), .bus_ready(br_w),
        .bus_rdata(rdat_w));

    bus_responder #(.BUS_BYTES(2)) rsp_n (
        .clk(clk), .rst_n(rst_n), .wait_cfg(wait_cfg), .bus_addr(ba_n),
        .bus_be(be_n), .bus_wdata(wd_n), .bus_write(bw_n),
        .bus_addr_strobe(as_n), .bus_active(act_n), .bus_ready(br_n),
        .bus_rdata(rdat_n));

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_of(input bit nar, input int a);
        return nar ? rsp_n.mem[a & 63] : rsp_w.mem[a & 63];
    endfunction

    function automatic int nlog_of(input bit nar);
        return nar ? rsp_n.nlog : rsp_w.nlog;
    endfunction

    // Issue one request, follow it to completion and check every outcome
    task automatic do_req(input bit nar, input int addr, input int size,
                          input bit wr, input logic [31:0] wd, input int waits,
                          input string tag, input int inject_at);
        int bb = nar ? 2 : 4;
        int n_exp = 0;
        int prev_w = -1;
        logic [31:0] e_addr [0:3];
        logic [3:0]  e_be [0:3];
        logic [31:0] e_wd [0:3];
        logic [31:0] e_rd = '0;
        logic [7:0]  before_lo, before_hi;
        int base, lat;
        bit seen;
        for (int t = 0; t < 4; t++) begin e_addr[t] = '0; e_be[t] = '0; e_wd[t] = '0; end
        for (int k = 0; k < size; k++) begin
            int a = addr + k;
            int w = (a / bb) * bb;
            if (w != prev_w) begin n_exp++; prev_w = w; end
            e_addr[n_exp-1] = 32'(w);
            e_be[n_exp-1][a - w] = 1'b1;
            e_wd[n_exp-1][8*(a-w) +: 8] = wd[8*k +: 8];
            e_rd[8*k +: 8] = mem_of(nar, a);
        end
        before_lo = mem_of(nar, addr - 1);
        before_hi = mem_of(nar, addr + size);
        base = nlog_of(nar);

        @(negedge clk);
        check((nar ? rdy_n : rdy_w) == 1'b1, "R1", "ready while idle",
              32'(nar ? rdy_n : rdy_w), 32'd1);
        wait_cfg  = waits;
        req_addr  = 32'(addr);
        req_size  = 3'(size);
        req_write = wr;
        req_wdata = wd;
        if (nar) vld_n = 1'b1; else vld_w = 1'b1;
        @(posedge clk);
        @(negedge clk);
        vld_n = 1'b0; vld_w = 1'b0;
        lat = 1;
        seen = 0;
        while (!seen && lat < 100) begin
            if (nar ? done_n : done_w) begin
                seen = 1;
            end else begin
                if (inject_at != 0 && lat == inject_at) begin
                    check((nar ? rdy_n : rdy_w) == 1'b0, "R1", "ready while busy",
                          32'(nar ? rdy_n : rdy_w), 32'd0);
                    req_addr = 32'd40; req_size = 3'd4; req_write = 1'b1;
                    req_wdata = 32'hDEADBEEF;
                    if (nar) vld_n = 1'b1; else vld_w = 1'b1;
                end else begin
                    vld_n = 1'b0; vld_w = 1'b0;
                end
                @(negedge clk);
                lat++;
            end
        end
        vld_n = 1'b0; vld_w = 1'b0;
        check(lat == n_exp * (2 + waits) + 1, "R7", "done latency",
              32'(lat), 32'(n_exp * (2 + waits) + 1));
        check(int'(nar ? cnt_n : cnt_w) == n_exp, tag, "transaction count",
              32'(nar ? cnt_n : cnt_w), 32'(n_exp));
        check(nlog_of(nar) - base == n_exp, "R3", "transactions seen on bus",
              32'(nlog_of(nar) - base), 32'(n_exp));
        for (int t = 0; t < n_exp && t < 4; t++) begin
            logic [31:0] la = nar ? rsp_n.log_addr[(base+t) & 127] : rsp_w.log_addr[(base+t) & 127];
            logic [3:0]  lb = nar ? rsp_n.log_be[(base+t) & 127]   : rsp_w.log_be[(base+t) & 127];
            logic [31:0] lw = nar ? rsp_n.log_wd[(base+t) & 127]   : rsp_w.log_wd[(base+t) & 127];
            check(la == e_addr[t], "R2", "aligned address", la, e_addr[t]);
            check(lb == e_be[t], "R4", "byte enables", 32'(lb), 32'(e_be[t]));
            if (wr) check(lw == e_wd[t], "R8", "steered write data", lw, e_wd[t]);
        end
        if (wr) begin
            for (int k = 0; k < size; k++) begin
                check(mem_of(nar, addr + k) == wd[8*k +: 8], "R8", "written byte",
                      32'(mem_of(nar, addr + k)), 32'(wd[8*k +: 8]));
            end
            check(mem_of(nar, addr - 1) == before_lo, "R4", "byte below untouched",
                  32'(mem_of(nar, addr - 1)), 32'(before_lo));
            check(mem_of(nar, addr + size) == before_hi, "R4", "byte above untouched",
                  32'(mem_of(nar, addr + size)), 32'(before_hi));
        end else begin
            check((nar ? rd_n : rd_w) == e_rd, "R9", "read result",
                  nar ? rd_n : rd_w, e_rd);
        end
        @(negedge clk);
        check((nar ? done_n : done_w) == 1'b0, "R10", "done is one clock",
              32'(nar ? done_n : done_w), 32'd0);
        check(int'(nar ? cnt_n : cnt_w) == n_exp, "R10", "count held",
              32'(nar ? cnt_n : cnt_w), 32'(n_exp));
        if (!wr) check((nar ? rd_n : rd_w) == e_rd, "R9", "result held",
                       nar ? rd_n : rd_w, e_rd);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(rdy_w && rdy_n, "R1", "ready after reset", 32'(rdy_w & rdy_n), 32'd1);
        check(be_w == '0 && be_n == '0, "R4", "no enables after reset", 32'({be_w, be_n}), 32'd0);
        check(!done_w && !done_n, "R10", "no done after reset", 32'(done_w | done_n), 32'd0);
        check(cnt_w == '0 && act_w == 1'b0, "R10", "count zero after reset", 32'(cnt_w), 32'd0);
    endtask

    task automatic t_wide_dwords();   // R5: offsets 0..3
        do_req(0, 8, 4, 0, '0, 0, "R5", 0);
        do_req(0, 17, 4, 0, '0, 0, "R5", 0);
        do_req(0, 18, 4, 0, '0, 0, "R5", 0);
        do_req(0, 19, 4, 0, '0, 0, "R5", 0);
    endtask

    task automatic t_wide_words();    // R5: word inside or across a boundary
        do_req(0, 21, 2, 0, '0, 0, "R5", 0);
        do_req(0, 22, 2, 0, '0, 0, "R5", 0);
        do_req(0, 23, 2, 0, '0, 0, "R5", 0);
    endtask

    task automatic t_narrow_dwords(); // R6: offset 3 and offset 6
        do_req(1, 3, 4, 0, '0, 0, "R6", 0);
        do_req(1, 6, 4, 0, '0, 0, "R6", 0);
        do_req(1, 9, 2, 0, '0, 0, "R3", 0);
    endtask

    task automatic t_bytes();         // R3: single bytes on both widths
        do_req(0, 30, 1, 0, '0, 0, "R3", 0);
        do_req(1, 31, 1, 0, '0, 0, "R3", 0);
    endtask

    task automatic t_waits();         // R7: ready held low extends data phase
        do_req(0, 13, 4, 0, '0, 2, "R7", 0);
        do_req(1, 27, 4, 0, '0, 1, "R7", 0);
    endtask

    task automatic t_writes();        // R8: lane steering and exact enables
        do_req(0, 37, 4, 1, 32'hA1B2C3D4, 0, "R5", 0);
        do_req(0, 50, 2, 1, 32'h00005A6B, 1, "R5", 0);
        do_req(1, 45, 2, 1, 32'h00007788, 0, "R3", 0);
        do_req(1, 55, 4, 1, 32'h11223344, 0, "R6", 0);
        do_req(0, 37, 4, 0, '0, 0, "R9", 0);
    endtask

    task automatic t_ignored();       // R1: request while busy has no effect
        logic [7:0] keep [0:3];
        for (int k = 0; k < 4; k++) keep[k] = mem_of(0, 40 + k);
        do_req(0, 1, 4, 0, '0, 2, "R1", 2);
        for (int k = 0; k < 4; k++) begin
            check(mem_of(0, 40 + k) == keep[k], "R1", "ignored write left memory",
                  32'(mem_of(0, 40 + k)), 32'(keep[k]));
        end
        check(rdy_w == 1'b1 && act_w == 1'b0, "R1", "idle after ignored request",
              32'(rdy_w), 32'd1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_wide_dwords();
        t_wide_words();
        t_narrow_dwords();
        t_bytes();
        t_waits();
        t_writes();
        t_ignored();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule